// File: doc/BRIEF.md
# Logical OR Execute Unit

This block is the execute stage for the inclusive OR family of a byte-addressed general-purpose instruction set. A decoder hands it the primary opcode byte, the three-bit register field of the ModRM byte, an operand-size flag and the two operand values that have already been fetched. The source value is either a register value or an immediate, placed in the low bits of the source input. The unit works out which OR form the opcode is and at what width it runs. Where the form asks for it, it sign-extends a one-byte immediate. It then produces the result, a write-back enable and the status flags.

All outputs are registered, so every result appears one clock after its inputs are sampled. Address generation, segment and paging checks and faults are handled elsewhere. This unit sees only operand values. Narrow operations keep the destination's upper bits, so the result can be written back as a full 32-bit register value.

Top module: `or_exec_unit`

## Requirements
- R1: For a valid OR form, each result bit within the active width is 0 only when both the destination bit and the (possibly extended) source bit are 0, and 1 otherwise.
- R2: For a valid OR form, flagOf and flagCf are 0, and afUndef is 1 to mark the auxiliary-carry flag as undefined.
- R3: flagSf equals the top bit of the result at the active width (bit 7, 15 or 31). flagZf is 1 exactly when the result bits within the active width are all zero.
- R4: flagPf is 1 when result bits 7:0 hold an even number of ones, whatever the active width.
- R5: Opcode 0x0C is the 8-bit accumulator-immediate form. Opcode 0x0D is the accumulator-immediate form at 32 bits when opSize32=1 and at 16 bits when opSize32=0.
- R6: Opcodes 0x80, 0x81 and 0x83 are OR forms only when modrmReg equals 1. With any other modrmReg value they are treated as non-OR opcodes.
- R7: Opcode 0x80 is 8-bit and uses srcVal[7:0]. Opcode 0x81 uses srcVal at the 16- or 32-bit width set by opSize32. Opcode 0x83 runs at 16 or 32 bits and sign-extends srcVal[7:0] from bit 7, ignoring srcVal[31:8].
- R8: Opcodes 0x08 and 0x0A are 8-bit. Opcodes 0x09 and 0x0B are 16- or 32-bit as set by opSize32. All four assert wbEn.
- R9: In 8-bit operations result[31:8] equals dstVal[31:8]. In 16-bit operations result[31:16] equals dstVal[31:16].
- R10: When inValid is 0 or the opcode is not an OR form, outValid, wbEn, afUndef and all five flags are 0, and result equals dstVal.
- R11: The outputs change one rising clock edge after the inputs are sampled. While rstN is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Operands and opcode are presented this cycle |
| opcode | input | 8 | Primary opcode byte |
| modrmReg | input | 3 | Register/extension field of the ModRM byte |
| opSize32 | input | 1 | 1 selects 32-bit, 0 selects 16-bit for non-byte forms |
| dstVal | input | 32 | Destination operand value |
| srcVal | input | 32 | Source operand, register value or immediate in the low bits |
| outValid | output | 1 | A valid OR result is presented |
| wbEn | output | 1 | Write result back to the destination |
| result | output | 32 | Result, upper bits kept from the destination for narrow widths |
| flagSf | output | 1 | Sign flag |
| flagZf | output | 1 | Zero flag |
| flagPf | output | 1 | Parity flag (low byte, even) |
| flagOf | output | 1 | Overflow flag, always cleared |
| flagCf | output | 1 | Carry flag, always cleared |
| afUndef | output | 1 | Auxiliary-carry flag left undefined |

## Verification
Every output of this unit sits behind one register stage, so the result, write-back enable and flags for a set of inputs are due on the first rising edge after those inputs are applied. The bench drives inputs on a falling edge and lets exactly one rising edge pass. It compares at the following falling edge, before it applies the next vector, so each comparison pairs a result with the vector that produced it. The reset values are checked while rstN is still low, before any input edge can have an effect.

// File: rtl/orx_pkg.sv
package orx_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2
  } opWidth_t;

  // strobes from decode to the datapath
  typedef struct packed {
    logic     isOr;
    opWidth_t width;
    logic     sextByte;
  } orCtrl_t;
endpackage

// File: rtl/or_ctrl.sv
module or_ctrl
  import orx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] opcode,
  input  logic [2:0] modrmReg,
  input  logic       opSize32,
  output orCtrl_t    strobes
);
  localparam logic [2:0] GRP1_OR = 3'd1;

  opWidth_t bigWidth;
  assign bigWidth = opSize32 ? SZ_D : SZ_W;

  always_comb begin
    strobes = '{isOr: 1'b0, width: SZ_B, sextByte: 1'b0};
    unique case (opcode)
      8'h08, 8'h0A, 8'h0C: begin
        strobes.isOr  = inValid;
        strobes.width = SZ_B;
      end
      8'h09, 8'h0B, 8'h0D: begin
        strobes.isOr  = inValid;
        strobes.width = bigWidth;
      end
      8'h80: begin
        strobes.isOr  = inValid && (modrmReg == GRP1_OR);
        strobes.width = SZ_B;
      end
      8'h81: begin
        strobes.isOr  = inValid && (modrmReg == GRP1_OR);
        strobes.width = bigWidth;
      end
      8'h83: begin
        strobes.isOr     = inValid && (modrmReg == GRP1_OR);
        strobes.width    = bigWidth;
        strobes.sextByte = 1'b1;
      end
      default: ;
    endcase
  end

  // R7
  sext_never_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sextByte |-> (strobes.width != SZ_B));

  // R6
  grp1_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opcode[7:2] == 6'b100000 && modrmReg != GRP1_OR) |-> !strobes.isOr);
endmodule

// File: rtl/or_dpath.sv
module or_dpath
  import orx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  orCtrl_t           strobes,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  output logic              outValid,
  output logic              wbEn,
  output logic [DATA_W-1:0] result,
  output logic              flagSf,
  output logic              flagZf,
  output logic              flagPf,
  output logic              flagOf,
  output logic              flagCf,
  output logic              afUndef
);
  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] orValue;
  logic              signBit;
  logic              zeroBit;
  logic              parityBit;
  opWidth_t          widthQ;

  always_comb begin
    unique case (strobes.width)
      SZ_B:    widthMask = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
      SZ_W:    widthMask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default: widthMask = {DATA_W{1'b1}};
    endcase
  end

  assign operandB = strobes.sextByte
                  ? {{(DATA_W-BYTE_W){srcVal[BYTE_W-1]}}, srcVal[BYTE_W-1:0]}
                  : srcVal;

  // narrow widths leave the destination's upper bits intact
  assign orValue = dstVal | (operandB & widthMask);

  always_comb begin
    unique case (strobes.width)
      SZ_B:    signBit = orValue[BYTE_W-1];
      SZ_W:    signBit = orValue[HALF_W-1];
      default: signBit = orValue[DATA_W-1];
    endcase
  end

  assign zeroBit   = ((orValue & widthMask) == '0);
  assign parityBit = ~^orValue[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wbEn     <= 1'b0;
      result   <= '0;
      flagSf   <= 1'b0;
      flagZf   <= 1'b0;
      flagPf   <= 1'b0;
      flagOf   <= 1'b0;
      flagCf   <= 1'b0;
      afUndef  <= 1'b0;
      widthQ   <= SZ_B;
    end else begin
      outValid <= strobes.isOr;
      wbEn     <= strobes.isOr;
      result   <= strobes.isOr ? orValue : dstVal;
      flagSf   <= strobes.isOr && signBit;
      flagZf   <= strobes.isOr && zeroBit;
      flagPf   <= strobes.isOr && parityBit;
      flagOf   <= 1'b0;
      flagCf   <= 1'b0;
      afUndef  <= strobes.isOr;
      widthQ   <= strobes.width;
    end
  end

  // R1
  covers_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((result | $past(dstVal)) == result));

  // R2
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (!flagOf && !flagCf && afUndef));

  // R3
  zero_not_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagZf) |-> !flagSf);

  // R4
  zero_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagZf) |-> flagPf);

  // R9
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && widthQ == SZ_B) |-> (result[DATA_W-1:BYTE_W] == $past(dstVal[DATA_W-1:BYTE_W])));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!wbEn && !flagSf && !flagZf && !flagPf && !afUndef));
endmodule

// File: rtl/or_exec_unit.sv
module or_exec_unit
  import orx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  opcode,
  input  logic [2:0]  modrmReg,
  input  logic        opSize32,
  input  logic [31:0] dstVal,
  input  logic [31:0] srcVal,
  output logic        outValid,
  output logic        wbEn,
  output logic [31:0] result,
  output logic        flagSf,
  output logic        flagZf,
  output logic        flagPf,
  output logic        flagOf,
  output logic        flagCf,
  output logic        afUndef
);
  orCtrl_t strobes;

  or_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .modrmReg (modrmReg),
    .opSize32 (opSize32),
    .strobes  (strobes)
  );

  or_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dstVal   (dstVal),
    .srcVal   (srcVal),
    .outValid (outValid),
    .wbEn     (wbEn),
    .result   (result),
    .flagSf   (flagSf),
    .flagZf   (flagZf),
    .flagPf   (flagPf),
    .flagOf   (flagOf),
    .flagCf   (flagCf),
    .afUndef  (afUndef)
  );
endmodule

// File: tb/or_exec_unit_tb.sv
module or_exec_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [2:0]  modrmReg = 3'd0;
  logic        opSize32 = 1'b0;
  logic [31:0] dstVal = '0;
  logic [31:0] srcVal = '0;
  logic        outValid, wbEn, flagSf, flagZf, flagPf, flagOf, flagCf, afUndef;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  or_exec_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .modrmReg(modrmReg), .opSize32(opSize32), .dstVal(dstVal), .srcVal(srcVal),
    .outValid(outValid), .wbEn(wbEn), .result(result), .flagSf(flagSf),
    .flagZf(flagZf), .flagPf(flagPf), .flagOf(flagOf), .flagCf(flagCf),
    .afUndef(afUndef)
  );

  // expected: {valid, wb, sf, zf, pf, of, cf, af, result}
  function automatic logic [39:0] model(input logic vin, input logic [7:0] op,
      input logic [2:0] rg, input logic s32, input logic [31:0] d, input logic [31:0] s);
    int bits;
    logic ok;
    logic [31:0] b, r;
    logic sf, zf, pf;
    ok = 1'b0; bits = 8; b = s;
    case (op)
      8'h08, 8'h0A, 8'h0C: begin ok = 1; bits = 8; end
      8'h09, 8'h0B, 8'h0D: begin ok = 1; bits = s32 ? 32 : 16; end
      8'h80: begin ok = (rg == 3'd1); bits = 8; end
      8'h81: begin ok = (rg == 3'd1); bits = s32 ? 32 : 16; end
      8'h83: begin ok = (rg == 3'd1); bits = s32 ? 32 : 16;
                   b = {{24{s[7]}}, s[7:0]}; end
      default: ok = 0;
    endcase
    ok = ok && vin;
    if (!ok) return {8'b0, d};
    r = d;
    for (int i = 0; i < bits; i++) r[i] = d[i] | b[i];
    sf = r[bits-1];
    zf = 1'b1;
    for (int i = 0; i < bits; i++) if (r[i]) zf = 1'b0;
    pf = ~(r[0]^r[1]^r[2]^r[3]^r[4]^r[5]^r[6]^r[7]);
    return {1'b1, 1'b1, sf, zf, pf, 1'b0, 1'b0, 1'b1, r};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic vin, input logic [7:0] op,
      input logic [2:0] rg, input logic s32, input logic [31:0] d, input logic [31:0] s);
    logic [39:0] e;
    e = model(vin, op, rg, s32, d, s);
    inValid = vin; opcode = op; modrmReg = rg; opSize32 = s32; dstVal = d; srcVal = s;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R1 result"},      result, e[31:0]);
    chk({tag, " R10 valid/wb"},   {30'b0, outValid, wbEn}, {30'b0, e[39:38]});
    chk({tag, " R3 sf/zf"},       {30'b0, flagSf, flagZf}, {30'b0, e[37:36]});
    chk({tag, " R4 pf"},          {31'b0, flagPf}, {31'b0, e[35]});
    chk({tag, " R2 of/cf/af"},    {29'b0, flagOf, flagCf, afUndef}, {29'b0, e[34:32]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [10];
    void'($urandom(32'd20240611));
    ops = '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h80, 8'h81, 8'h83, 8'h00};
    // R11 reset state, inputs live while held in reset
    inValid = 1; opcode = 8'h0D; dstVal = 32'hFFFF_FFFF; srcVal = 32'h1;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {23'b0, outValid, wbEn, flagSf, flagZf, flagPf, flagOf, flagCf, afUndef, 1'b0},
        32'h0);
    chk("R11 reset result", result, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    apply("R5 0C byte",         1, 8'h0C, 3'd5, 1, 32'hAABB_CC00, 32'h0000_0081);
    apply("R5 0D word",         1, 8'h0D, 3'd0, 0, 32'h1234_0000, 32'hFFFF_8000);
    apply("R5 0D dword",        1, 8'h0D, 3'd0, 1, 32'h0000_0000, 32'h8000_0000);
    apply("R3 zero dword",      1, 8'h0B, 3'd2, 1, 32'h0, 32'h0);
    apply("R9 zero byte upper", 1, 8'h0A, 3'd0, 1, 32'hFFFF_FF00, 32'hFFFF_FF00);
    apply("R9 word upper",      1, 8'h09, 3'd0, 0, 32'hDEAD_0000, 32'hFFFF_0001);
    apply("R7 83 neg imm",      1, 8'h83, 3'd1, 0, 32'h5555_0000, 32'h0000_0080);
    apply("R7 83 pos imm",      1, 8'h83, 3'd1, 1, 32'h0000_0000, 32'hFFFF_FF7F);
    apply("R7 80 byte imm",     1, 8'h80, 3'd1, 1, 32'h0F0F_0F00, 32'hFFFF_FF03);
    apply("R7 81 word imm",     1, 8'h81, 3'd1, 0, 32'h0000_0000, 32'hABCD_0000);
    apply("R6 80 reg2",         1, 8'h80, 3'd2, 1, 32'h1111_2222, 32'hFFFF_FFFF);
    apply("R6 83 reg0",         1, 8'h83, 3'd0, 1, 32'h0, 32'hFF);
    apply("R8 08 byte",         1, 8'h08, 3'd3, 1, 32'h0000_0001, 32'h0000_0002);
    apply("R8 0B dword",        1, 8'h0B, 3'd3, 1, 32'h8000_0001, 32'h0000_0006);
    apply("R10 bad opcode",     1, 8'h01, 3'd1, 1, 32'hCAFE_F00D, 32'hFFFF_FFFF);
    apply("R10 not valid",      0, 8'h09, 3'd1, 1, 32'h0BAD_BEEF, 32'hFFFF_FFFF);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      op = ops[$urandom_range(0, 9)];
      if (op == 8'h00) op = 8'($urandom);
      apply("rand", ($urandom_range(0, 7) != 0), op, 3'($urandom_range(0, 2)),
            1'($urandom), ($urandom_range(0, 4) == 0) ? 32'h0 : $urandom,
            ($urandom_range(0, 4) == 0) ? 32'h0 : $urandom);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule